// File: doc/BRIEF.md
# Marker Lock Supervisor

This block decides whether a receiver is aligned to a repeating marker pattern, such as the boundaries of data blocks or of whole frames. Each cycle it is told whether a marker was detected, whether the local timing expects a marker at this cycle, and how many bit errors the detected marker contained. Hysteresis counters keep the lock decision steady, so one corrupted or one spurious marker does not change the lock state. One copy can track block alignment and a second copy, driven by a slower expected-position strobe, can track frame alignment.

While hunting, a marker counts as a hit only when its error count is within the acquisition limit. A run of consecutive hits at the expected spacing declares lock. While locked, only markers at expected positions are judged, against a separate hold limit. A run of consecutive failures drops lock. The start pulse follows the marker by one cycle, because a marker is only known once its last bit has arrived. While locked, the pulse is issued at every expected position even when the marker itself was lost. Both run lengths and both error limits can be set through a byte-wide configuration write. Each run length is stored as its value minus one.

Top module: `sync_guard`

## Requirements
- R1: After reset, `locked` and `start_pulse` are low. The acquisition and hold error limits are both 2, the acquisition run length is 2 (stored 1) and the hold run length is 8 (stored 7).
- R2: A write with `cfg_sel`=0 loads the error limits: bits 7:4 are the acquisition limit and bits 3:0 are the hold limit. A write with `cfg_sel`=1 loads the run lengths: bits 7:4 are acquisition and bits 3:0 are hold, each stored as length minus one. Written values apply from the next cycle on. Without a write, the settings do not change.
- R3: While hunting, a detected marker whose error count is at most the acquisition limit is a hit. The first hit of a run may fall anywhere. Later hits must coincide with `mark_pos`. A good marker away from `mark_pos` restarts the run at one.
- R4: Lock is declared when the run reaches the acquisition length. `locked` rises in the cycle after the completing marker.
- R5: While hunting, a `mark_pos` cycle without a hit (no marker, or too many errors) clears the run.
- R6: While locked, a `mark_pos` cycle whose marker is absent or has more errors than the hold limit is a miss. A good marker at `mark_pos` clears the miss run.
- R7: Lock is dropped in the cycle after the miss run reaches the hold length. Hunting then starts from an empty run.
- R8: `start_pulse` is high for exactly one cycle after the marker that completes acquisition, and after every `mark_pos` cycle while locked, whether the marker was good or missed. The exception is the `mark_pos` cycle that drops lock.
- R9: While locked, markers away from `mark_pos` have no effect on `locked` or `start_pulse`.
- R10: A stored run length of 0 means a run of one: a single hit locks, and a single miss unlocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: error limits, 1: run lengths |
| cfg_data | input | 2*FIELD_W | Configuration byte: acquisition field in the upper half, hold field in the lower half |
| mark_det | input | 1 | Marker fully received this cycle |
| mark_pos | input | 1 | Local timing expects a marker this cycle |
| mark_err | input | ERR_W | Bit errors in the detected marker |
| locked | output | 1 | Alignment established |
| start_pulse | output | 1 | One-cycle start indication |

## Verification
The bench uses the default parameters: a 4-bit field and a 5-bit error count. Error values therefore span from below to far above any limit a 4-bit field can hold. The reset defaults are used to exercise the full 8-miss hold run and the 2-hit acquisition run. Reprogrammed settings then reach the one-length runs, a zero hold limit and a 3-hit acquisition run with an off-position restart. A long random stream with random configuration writes then compares every cycle against a behavioural model.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sg_state_e;
endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sg_cfg_regs.sv
module sg_cfg_regs #(
  parameter int FIELD_W = 4,
  parameter logic [2*FIELD_W-1:0] DEF_LIM  = 8'h22,
  parameter logic [2*FIELD_W-1:0] DEF_PROT = 8'h17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [2*FIELD_W-1:0] cfg_data,
  output logic [FIELD_W-1:0]   lim_acq,
  output logic [FIELD_W-1:0]   lim_hold,
  output logic [FIELD_W-1:0]   run_acq,
  output logic [FIELD_W-1:0]   run_hold
);
  localparam int CFG_W = 2 * FIELD_W;

  logic [CFG_W-1:0] lim_q, lim_d, run_q, run_d;
  logic             lim_en, run_en;

  always_comb begin
    lim_en = cfg_wr && !cfg_sel;
    run_en = cfg_wr &&  cfg_sel;
    lim_d  = lim_en ? cfg_data : lim_q;
    run_d  = run_en ? cfg_data : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= DEF_LIM;
      run_q <= DEF_PROT;
    end else begin
      lim_q <= lim_d;
      run_q <= run_d;
    end
  end

  assign lim_acq  = lim_q[CFG_W-1:FIELD_W];
  assign lim_hold = lim_q[FIELD_W-1:0];
  assign run_acq  = run_q[CFG_W-1:FIELD_W];
  assign run_hold = run_q[FIELD_W-1:0];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(lim_q) && $stable(run_q))); // R2
endmodule

// File: rtl/sg_lock_fsm.sv
module sg_lock_fsm
  import sg_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int ERR_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mark_det,
  input  logic               mark_pos,
  input  logic [ERR_W-1:0]   mark_err,
  input  logic [FIELD_W-1:0] lim_acq,
  input  logic [FIELD_W-1:0] lim_hold,
  input  logic [FIELD_W-1:0] run_acq,
  input  logic [FIELD_W-1:0] run_hold,
  output logic               locked,
  output logic               start_pulse
);
  localparam int CW = (ERR_W > FIELD_W) ? ERR_W : FIELD_W;

  sg_state_e         st_q, st_d;
  logic [FIELD_W-1:0] hit_q, hit_d, miss_q, miss_d, base;
  logic              pulse_q, pulse_d;
  logic [CW-1:0]     err_x;
  logic              good_acq, good_hold, on_time, restart;

  always_comb begin
    err_x     = CW'(mark_err);
    good_acq  = mark_det && (err_x <= CW'(lim_acq));
    good_hold = mark_det && (err_x <= CW'(lim_hold));
    on_time   = good_acq && (mark_pos || (hit_q == '0));
    restart   = good_acq && !on_time;
    base      = restart ? '0 : hit_q;

    st_d    = st_q;
    hit_d   = hit_q;
    miss_d  = miss_q;
    pulse_d = 1'b0;

    unique case (st_q)
      ST_HUNT: begin
        if (on_time || restart) begin
          if (base >= run_acq) begin
            st_d    = ST_LOCK;
            hit_d   = '0;
            miss_d  = '0;
            pulse_d = 1'b1;
          end else begin
            hit_d = base + 1'b1;
          end
        end else if (mark_pos) begin
          hit_d = '0;
        end
      end
      ST_LOCK: begin
        if (mark_pos) begin
          if (good_hold) begin
            miss_d  = '0;
            pulse_d = 1'b1;
          end else if (miss_q >= run_hold) begin
            st_d   = ST_HUNT;
            miss_d = '0;
            hit_d  = '0;
          end else begin
            miss_d  = miss_q + 1'b1;
            pulse_d = 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      hit_q   <= '0;
      miss_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
      pulse_q <= pulse_d;
    end
  end

  assign locked      = (st_q == ST_LOCK);
  assign start_pulse = pulse_q;

  AST_PULSE_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> locked); // R8
  AST_LOCK_AFTER_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(mark_det)); // R4
  AST_DROP_AT_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(mark_pos)); // R7
  AST_FLYWHEEL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && mark_pos) |=> (start_pulse || !locked)); // R8
  AST_OFFPOS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !mark_pos) |=> (locked && !start_pulse)); // R9
endmodule

// File: rtl/sync_guard.sv
module sync_guard #(
  parameter int FIELD_W = 4,
  parameter int ERR_W   = 5,
  parameter logic [2*FIELD_W-1:0] DEF_LIM  = 8'h22,
  parameter logic [2*FIELD_W-1:0] DEF_PROT = 8'h17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [2*FIELD_W-1:0] cfg_data,
  input  logic                 mark_det,
  input  logic                 mark_pos,
  input  logic [ERR_W-1:0]     mark_err,
  output logic                 locked,
  output logic                 start_pulse
);
  logic               rst_i_n;
  logic [FIELD_W-1:0] lim_acq, lim_hold, run_acq, run_hold;

  sg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sg_cfg_regs #(
    .FIELD_W  (FIELD_W),
    .DEF_LIM  (DEF_LIM),
    .DEF_PROT (DEF_PROT)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .lim_acq  (lim_acq),
    .lim_hold (lim_hold),
    .run_acq  (run_acq),
    .run_hold (run_hold)
  );

  sg_lock_fsm #(
    .FIELD_W (FIELD_W),
    .ERR_W   (ERR_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .mark_det    (mark_det),
    .mark_pos    (mark_pos),
    .mark_err    (mark_err),
    .lim_acq     (lim_acq),
    .lim_hold    (lim_hold),
    .run_acq     (run_acq),
    .run_hold    (run_hold),
    .locked      (locked),
    .start_pulse (start_pulse)
  );
endmodule

// File: tb/sync_guard_tb_top.sv
module sync_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, cfg_wr, cfg_sel, mark_det, mark_pos;
  logic [7:0] cfg_data;
  logic [4:0] mark_err;
  logic       locked, start_pulse;

  always #2 clk = ~clk;

  sync_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mark_det(mark_det), .mark_pos(mark_pos),
    .mark_err(mark_err), .locked(locked), .start_pulse(start_pulse)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  int    m_lock, m_hits, m_miss, m_pulse, m_la, m_lh, m_ra, m_rh;

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lock = 0; m_hits = 0; m_miss = 0; m_pulse = 0;
    m_la = 2; m_lh = 2; m_ra = 1; m_rh = 7;
  endtask

  task automatic model_step(bit det, bit pos, int err, bit wr, bit sel, int data);
    int n;
    m_pulse = 0;
    if (m_lock == 0) begin
      if (det && err <= m_la) begin
        n = (pos || m_hits == 0) ? m_hits + 1 : 1;
        if (n >= m_ra + 1) begin
          m_lock = 1; m_hits = 0; m_miss = 0; m_pulse = 1;
        end else m_hits = n;
      end else if (pos) m_hits = 0;
    end else if (pos) begin
      if (det && err <= m_lh) begin
        m_miss = 0; m_pulse = 1;
      end else begin
        m_miss = m_miss + 1;
        if (m_miss >= m_rh + 1) begin
          m_lock = 0; m_miss = 0; m_hits = 0;
        end else m_pulse = 1;
      end
    end
    if (wr) begin
      if (sel) begin m_ra = (data >> 4) & 15; m_rh = data & 15; end
      else     begin m_la = (data >> 4) & 15; m_lh = data & 15; end
    end
  endtask

  task automatic cyc(bit det, bit pos, int err, bit wr = 0, bit sel = 0, int data = 0);
    mark_det = det; mark_pos = pos; mark_err = 5'(err);
    cfg_wr = wr; cfg_sel = sel; cfg_data = 8'(data);
    @(negedge clk);
    model_step(det, pos, err, wr, sel, data);
    chk(cur_req, locked, m_lock[0], "locked");
    chk(cur_req, start_pulse, m_pulse[0], "start_pulse");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic do_reset();
    mark_det = 0; mark_pos = 0; mark_err = '0;
    cfg_wr = 0; cfg_sel = 0; cfg_data = '0;
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    chk("R1", locked, 1'b0, "locked in reset");
    chk("R1", start_pulse, 1'b0, "start_pulse in reset");
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    int seed = 7;
    do_reset();

    // R1 / R3 / R4: default acquisition limit 2, run of 2
    cur_req = "R3";
    cyc(1, 1, 3); idle(2);
    chk("R3", locked, 1'b0, "error 3 above default limit");
    cyc(1, 1, 2); idle(2);
    cur_req = "R4";
    cyc(1, 1, 2);
    chk("R4", locked, 1'b1, "lock after second hit");
    chk("R8", start_pulse, 1'b1, "pulse after acquiring marker");
    idle(2);

    // R6 / R7 / R8: flywheel, a good marker clears, default hold run 8
    cur_req = "R6";
    for (int i = 0; i < 3; i++) begin cyc(0, 1, 0); idle(2); end
    cyc(1, 1, 2); idle(2);
    cur_req = "R7";
    for (int i = 0; i < 7; i++) begin
      cyc(0, 1, 0);
      chk("R8", start_pulse, 1'b1, "flywheel pulse on missed marker");
      idle(2);
    end
    chk("R7", locked, 1'b1, "still locked after 7 misses");
    cyc(0, 1, 0);
    chk("R7", locked, 1'b0, "dropped after 8 misses");
    chk("R8", start_pulse, 1'b0, "no pulse on dropping miss");
    idle(2);

    // R5: miss while hunting clears the run
    cur_req = "R5";
    cyc(1, 1, 0); idle(1);
    cyc(1, 1, 9); idle(1);
    cyc(1, 1, 0); idle(1);
    chk("R5", locked, 1'b0, "run cleared by bad marker");
    cyc(1, 1, 1); idle(1);
    chk("R4", locked, 1'b1, "locked after fresh run of 2");

    // R9: off-position markers ignored while locked
    cur_req = "R9";
    cyc(1, 0, 31); cyc(1, 0, 0); cyc(0, 0, 0);
    chk("R9", locked, 1'b1, "off-position markers ignored");
    chk("R9", start_pulse, 1'b0, "no pulse off position");

    // R2 / R10: limits acq 5 hold 0, runs of one
    do_reset();
    cur_req = "R2";
    cyc(0, 0, 0, 1, 0, 8'h50);
    cyc(0, 0, 0, 1, 1, 8'h00);
    cur_req = "R10";
    cyc(1, 0, 5);
    chk("R10", locked, 1'b1, "single hit locks with stored 0");
    idle(2);
    cur_req = "R6";
    cyc(1, 1, 0); idle(1);
    cyc(1, 1, 1);
    chk("R6", locked, 1'b0, "error above hold limit 0 drops at run 1");
    idle(2);

    // R3: off-position restart with acquisition run 3
    cur_req = "R3";
    cyc(0, 0, 0, 1, 1, 8'h27);
    cyc(1, 1, 0); idle(1);
    cyc(1, 0, 0); idle(1);
    cyc(1, 1, 0); idle(1);
    chk("R3", locked, 1'b0, "restart keeps run at 2");
    cyc(1, 1, 0);
    chk("R3", locked, 1'b1, "third hit locks");

    // random stream against the model
    do_reset();
    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      bit pos = (i % 5 == 4);
      bit det = ($urandom(seed) % 4) != 0;
      int err = $urandom % 8;
      bit wr  = ($urandom % 200) == 0;
      seed = 0;
      cyc(det, pos, err, wr, 1'($urandom % 2), $urandom % 256);
    end

    finish_run();
  end
endmodule